// File: doc/BRIEF.md
# RTC Time Update Engine

This block holds the time-of-day and calendar counters of a real-time clock. It moves them forward by one second on each one-second tick from an outside prescaler. The counters are seconds, minutes, hours, day of week, date, month and year. It handles every carry across fields, including month lengths, leap years and the wrap of the two-digit year. A control register selects binary or BCD encoding and 12- or 24-hour hours. It also holds an update-inhibit bit and a daylight-saving enable. With daylight saving enabled, the engine makes the spring-forward jump by itself, and it makes the fall-back repeat only once per day.

Software reads and writes all counters through a small register bus. Writes take effect in the cycle they are presented, and reads are combinational. While the inhibit bit is set, ticks are ignored, so software can load a full time and date without a carry landing part-way through. After each completed advance the block gives a one-cycle update-ended pulse.

Top module: `rtc_update_engine`

## Requirements
- R1: With the inhibit bit (control bit 7) clear, a tick with no write in the same cycle advances the time by exactly one second. `upd_end` is high for exactly the one cycle after that tick edge.
- R2: With the inhibit bit set, a tick changes no counter and produces no `upd_end` pulse.
- R3: Seconds carry into minutes at 60, minutes carry into hours at 60, and hours carry into the day at 24. Day of week counts 1 to 7 with Sunday as 1, and wraps from 7 to 1.
- R4: On a day carry, the date wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, and 31 for the other months. February has 29 days when the year is divisible by 4 and 28 days otherwise. Month 12 wraps to 1, and year 99 wraps to 0.
- R5: Control bit 2 set means that every time and calendar byte is plain binary. Clear means packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R6: Control bit 1 set selects 24-hour hours (0 to 23). Clear selects 12-hour hours, where bit 7 of the hours byte is PM and bits 6:0 run 12, 1, ... 11. PM toggles on the step from 11:59:59 to 12:00:00.
- R7: With the daylight enable (control bit 0) set, the time steps from 1:59:59 AM straight to 3:00:00 AM. This happens on a Sunday (day of week 1) in month 4 with a date of 7 or less.
- R8: With the daylight enable set, the time steps from 1:59:59 AM back to 1:00:00 AM on a Sunday in month 10 with a date of 25 or more. This happens only the first time that day. Writing the date register re-arms the step.
- R9: With the daylight enable clear, both of those days step normally from 1:59:59 to 2:00:00.
- R10: The register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year and 7 control. A write is readable on the next cycle. When a write and a tick land in the same cycle, the write wins: the tick is dropped and no pulse follows.
- R11: All eight control bits read back as written, except for one case. A write that sets bit 7 while it was clear forces bit 4 to 0. After reset the control register reads 0x06 and the time reads 00:00:00 on day 1, 1 January year 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| upd_end | output | 1 | One-cycle pulse after each advance |

## Verification
The checker looks at the tick, write and pulse handshake on every cycle. After an enabled tick the pulse must follow, and a pulse must have a tick behind it. It also checks that the pulse stays low, and the seconds stay put, while the inhibit bit is set, and that a write always suppresses the pulse. The arithmetic can only be shown by the bench's scenarios that start from chosen times: carries, month lengths, leap years, BCD and 12-hour encodings, and both daylight jumps. The same holds for the once-only fall-back and for the control register's read-back.

// File: rtl/rtc_update_engine.sv
module rtc_update_engine #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          upd_end
);
  typedef logic [DW-1:0] byte_t;

  byte_t sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q, ctl_q;
  logic  fall_done_q;

  wire set_b = ctl_q[7];
  wire bin_b = ctl_q[2];
  wire h24_b = ctl_q[1];
  wire dse_b = ctl_q[0];

  function automatic byte_t dec(input byte_t x, input logic bin);
    dec = bin ? x : byte_t'({4'd0, x[7:4]} * 8'd10 + {4'd0, x[3:0]});
  endfunction

  function automatic byte_t enc(input byte_t v, input logic bin);
    byte_t t, o;
    t = v / 8'd10;
    o = v % 8'd10;
    enc = bin ? v : {t[3:0], o[3:0]};
  endfunction

  byte_t s, m, h, h12, dw, dt, mo, y, mlen;
  byte_t ns, nm, nh, nh12, ndw, ndt, nmo, ny;
  logic  nfall, at_159, spring, fall;

  always_comb begin
    s   = dec(sec_q, bin_b);
    m   = dec(min_q, bin_b);
    dw  = dec(dow_q, bin_b);
    dt  = dec(date_q, bin_b);
    mo  = dec(mon_q, bin_b);
    y   = dec(yr_q, bin_b);
    h12 = dec({1'b0, hr_q[6:0]}, bin_b);
    if (h24_b) h = dec(hr_q, bin_b);
    else       h = ((h12 == 8'd12) ? 8'd0 : h12) + (hr_q[7] ? 8'd12 : 8'd0);

    case (mo)
      8'd2:                     mlen = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  mlen = 8'd30;
      default:                  mlen = 8'd31;
    endcase

    at_159 = (h == 8'd1) && (m == 8'd59) && (s == 8'd59);
    spring = dse_b && at_159 && (mo == 8'd4)  && (dw == 8'd1) && (dt <= 8'd7);
    fall   = dse_b && at_159 && (mo == 8'd10) && (dw == 8'd1) && (dt >= 8'd25) && !fall_done_q;

    ns = s; nm = m; nh = h; ndw = dw; ndt = dt; nmo = mo; ny = y;
    nfall = fall_done_q;
    if (spring) begin
      nh = 8'd3; nm = 8'd0; ns = 8'd0;
    end else if (fall) begin
      nh = 8'd1; nm = 8'd0; ns = 8'd0; nfall = 1'b1;
    end else if (s < 8'd59) begin
      ns = s + 8'd1;
    end else begin
      ns = 8'd0;
      if (m < 8'd59) nm = m + 8'd1;
      else begin
        nm = 8'd0;
        if (h < 8'd23) nh = h + 8'd1;
        else begin
          nh    = 8'd0;
          nfall = 1'b0;
          ndw   = (dw >= 8'd7) ? 8'd1 : dw + 8'd1;
          if (dt >= mlen) begin
            ndt = 8'd1;
            if (mo >= 8'd12) begin
              nmo = 8'd1;
              ny  = (y >= 8'd99) ? 8'd0 : y + 8'd1;
            end else nmo = mo + 8'd1;
          end else ndt = dt + 8'd1;
        end
      end
    end
    nh12 = nh % 8'd12;
    if (nh12 == 8'd0) nh12 = 8'd12;
  end

  wire   advance = tick && !set_b && !wr_en;
  wire   set_rise = (wdata[7] && !set_b);
  byte_t hr_enc;
  assign hr_enc = h24_b ? enc(nh, bin_b) : {nh >= 8'd12, enc(nh12, bin_b)[6:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; dow_q <= 8'd1;
      date_q <= 8'd1; mon_q <= 8'd1; yr_q <= '0; ctl_q <= 8'h06;
      fall_done_q <= 1'b0;
      upd_end <= 1'b0;
    end else begin
      upd_end <= advance;
      if (wr_en) begin
        case (addr)
          3'd0: sec_q  <= wdata;
          3'd1: min_q  <= wdata;
          3'd2: hr_q   <= wdata;
          3'd3: dow_q  <= wdata;
          3'd4: begin date_q <= wdata; fall_done_q <= 1'b0; end
          3'd5: mon_q  <= wdata;
          3'd6: yr_q   <= wdata;
          default: ctl_q <= set_rise ? (wdata & 8'hEF) : wdata;
        endcase
      end else if (advance) begin
        sec_q  <= enc(ns, bin_b);
        min_q  <= enc(nm, bin_b);
        hr_q   <= hr_enc;
        dow_q  <= enc(ndw, bin_b);
        date_q <= enc(ndt, bin_b);
        mon_q  <= enc(nmo, bin_b);
        yr_q   <= enc(ny, bin_b);
        fall_done_q <= nfall;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = sec_q;
      3'd1: rdata = min_q;
      3'd2: rdata = hr_q;
      3'd3: rdata = dow_q;
      3'd4: rdata = date_q;
      3'd5: rdata = mon_q;
      3'd6: rdata = yr_q;
      default: rdata = ctl_q;
    endcase
  end
endmodule

module rtc_update_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic       upd_end,
  input logic       set_q,
  input logic [7:0] sec_q
);
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !set_q && !wr_en |=> upd_end); // R1
  AST_PULSE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |-> $past(tick)); // R1
  AST_INHIBIT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    set_q && !wr_en |=> !upd_end); // R2
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_q && !wr_en |=> $stable(sec_q)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !upd_end); // R10
endmodule

bind rtc_update_engine rtc_update_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .upd_end(upd_end), .set_q(ctl_q[7]), .sec_q(sec_q)
);

// File: tb/rtc_update_engine_test.sv
module rtc_update_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic upd_end;
  int checks = 0, fails = 0;
  bit done = 0;

  rtc_update_engine uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .upd_end(upd_end));

  always #4 clk = ~clk;

  // {req, ctl, sec,min,hr,dow,date,mon,yr, expected sec,min,hr,dow,date,mon,yr}
  localparam int NV = 16;
  localparam logic [123:0] VEC [NV] = '{
    {4'd1, 8'h06, 8'd5, 8'd0, 8'd0, 8'd3, 8'd10, 8'd5, 8'd21,  8'd6, 8'd0, 8'd0, 8'd3, 8'd10, 8'd5, 8'd21},   // R1
    {4'd3, 8'h06, 8'd59, 8'd59, 8'd23, 8'd7, 8'd10, 8'd5, 8'd21,  8'd0, 8'd0, 8'd0, 8'd1, 8'd11, 8'd5, 8'd21}, // R3
    {4'd3, 8'h06, 8'd59, 8'd15, 8'd8, 8'd2, 8'd10, 8'd5, 8'd21,  8'd0, 8'd16, 8'd8, 8'd2, 8'd10, 8'd5, 8'd21}, // R3
    {4'd4, 8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99,  8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00}, // R4
    {4'd4, 8'h06, 8'd59, 8'd59, 8'd23, 8'd2, 8'd28, 8'd2, 8'd24,  8'd0, 8'd0, 8'd0, 8'd3, 8'd29, 8'd2, 8'd24}, // R4
    {4'd4, 8'h06, 8'd59, 8'd59, 8'd23, 8'd2, 8'd28, 8'd2, 8'd23,  8'd0, 8'd0, 8'd0, 8'd3, 8'd1, 8'd3, 8'd23},  // R4
    {4'd4, 8'h06, 8'd59, 8'd59, 8'd23, 8'd5, 8'd29, 8'd2, 8'd24,  8'd0, 8'd0, 8'd0, 8'd6, 8'd1, 8'd3, 8'd24},  // R4
    {4'd4, 8'h06, 8'd59, 8'd59, 8'd23, 8'd5, 8'd30, 8'd4, 8'd21,  8'd0, 8'd0, 8'd0, 8'd6, 8'd1, 8'd5, 8'd21},  // R4
    {4'd4, 8'h06, 8'd59, 8'd59, 8'd23, 8'd5, 8'd30, 8'd1, 8'd21,  8'd0, 8'd0, 8'd0, 8'd6, 8'd31, 8'd1, 8'd21}, // R4
    {4'd5, 8'h02, 8'h19, 8'h00, 8'h00, 8'h03, 8'h10, 8'h05, 8'h21,  8'h20, 8'h00, 8'h00, 8'h03, 8'h10, 8'h05, 8'h21}, // R5
    {4'd5, 8'h06, 8'd9, 8'd0, 8'd0, 8'd3, 8'd10, 8'd5, 8'd21,  8'd10, 8'd0, 8'd0, 8'd3, 8'd10, 8'd5, 8'd21},  // R5
    {4'd6, 8'h00, 8'h59, 8'h59, 8'h11, 8'h03, 8'h10, 8'h05, 8'h21,  8'h00, 8'h00, 8'h92, 8'h03, 8'h10, 8'h05, 8'h21}, // R6
    {4'd6, 8'h00, 8'h59, 8'h59, 8'h92, 8'h03, 8'h10, 8'h05, 8'h21,  8'h00, 8'h00, 8'h81, 8'h03, 8'h10, 8'h05, 8'h21}, // R6
    {4'd6, 8'h00, 8'h59, 8'h59, 8'h91, 8'h04, 8'h10, 8'h05, 8'h21,  8'h00, 8'h00, 8'h12, 8'h05, 8'h11, 8'h05, 8'h21}, // R6
    {4'd7, 8'h07, 8'd59, 8'd59, 8'd1, 8'd1, 8'd3, 8'd4, 8'd21,  8'd0, 8'd0, 8'd3, 8'd1, 8'd3, 8'd4, 8'd21},   // R7
    {4'd7, 8'h01, 8'h59, 8'h59, 8'h01, 8'h01, 8'h03, 8'h04, 8'h21,  8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h04, 8'h21}  // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick_once(output logic pulse);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; pulse = upd_end;
  endtask

  task automatic load(input logic [7:0] c, input logic [55:0] t);
    wr(3'd7, c);
    for (int i = 0; i < 7; i++) wr(3'(i), t[55-8*i -: 8]);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] v, v2, v3;
    logic p;
    logic [55:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd(3'd7, v); check("R11 reset ctl", v, 8'h06);
    rd(3'd0, v); check("R11 reset sec", v, 8'h00);
    rd(3'd3, v); check("R11 reset dow", v, 8'h01);
    rd(3'd5, v); check("R11 reset month", v, 8'h01);
    check("R11 reset pulse", {7'd0, upd_end}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      load(VEC[k][119:112], VEC[k][111:56]);
      tick_once(p);
      check($sformatf("R1 pulse vec %0d", k), {7'd0, p}, 8'h01);
      for (int i = 0; i < 7; i++) begin
        rd(3'(i), v);
        got[55-8*i -: 8] = v;
      end
      checks++;
      if (got !== VEC[k][55:0]) begin
        fails++;
        $display("FAIL R%0d vec %0d: got 0x%014h expected 0x%014h", VEC[k][123:120], k, got, VEC[k][55:0]);
      end
    end

    // R9 no daylight jumps when disabled
    load(8'h06, {8'd59, 8'd59, 8'd1, 8'd1, 8'd3, 8'd4, 8'd21});
    tick_once(p); rd(3'd2, v); check("R9 april hour", v, 8'd2);
    load(8'h06, {8'd59, 8'd59, 8'd1, 8'd1, 8'd29, 8'd10, 8'd21});
    tick_once(p); rd(3'd2, v); rd(3'd1, v2); check("R9 october hour", v, 8'd2); check("R9 october min", v2, 8'd0);

    // R8 fall back once
    load(8'h07, {8'd59, 8'd59, 8'd1, 8'd1, 8'd29, 8'd10, 8'd21});
    tick_once(p); rd(3'd2, v); rd(3'd1, v2); rd(3'd0, v3);
    check("R8 first hour", v, 8'd1); check("R8 first min", v2, 8'd0); check("R8 first sec", v3, 8'd0);
    wr(3'd1, 8'd59); wr(3'd0, 8'd59);
    tick_once(p); rd(3'd2, v); rd(3'd1, v2);
    check("R8 second hour", v, 8'd2); check("R8 second min", v2, 8'd0);

    // R2 inhibit
    load(8'h06, {8'd10, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0});
    wr(3'd7, 8'h86);
    tick_once(p); check("R2 no pulse", {7'd0, p}, 8'h00);
    rd(3'd0, v); check("R2 sec held", v, 8'd10);
    wr(3'd7, 8'h06);

    // R10 write beats tick
    @(negedge clk); addr = 3'd0; wdata = 8'd30; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    check("R10 no pulse", {7'd0, upd_end}, 8'h00);
    rd(3'd0, v); check("R10 write kept", v, 8'd30);

    // R11 control read-back and UIE clear on inhibit rise
    wr(3'd7, 8'h16); rd(3'd7, v); check("R11 ctl uie", v, 8'h16);
    wr(3'd7, 8'h96); rd(3'd7, v); check("R11 set rise clears bit4", v, 8'h86);
    wr(3'd7, 8'hF6); rd(3'd7, v); check("R11 all bits", v, 8'hF6);
    wr(3'd7, 8'h06);

    done = 1;
    summary();
  end
endmodule